// File: doc/BRIEF.md
# Complementary Output Idle-State Controller

This block is the final output stage for four timer compare channels. Channels 1 to 3 each drive a main output and a complementary output, and channel 4 drives a main output only. While the master output enable is high, each channel follows its reference waveform. Dead-time insertion makes sure that a newly active output rises only after a programmable number of clock cycles, and that a pair never conducts at the same time.

When the master output enable falls, every output keeps its last level for the dead time and then moves to its own programmed idle level. The seven idle levels sit in a small configuration register. A protection level can be raised from 0 to 1, 2 or 3. At any nonzero level the idle levels are frozen, and only a reset lowers the level again. The compare logic that makes the reference waveforms and any fault-shutdown input sit outside this block.

Top module: `compl_idle_out`

## Requirements
- R1: After a synchronous reset the idle bits read 0, the protection level reads 0 and every main and complementary output is 0.
- R2: With `out_en` high, a change of `ref_wave[i]` sampled at clock edge E0 drives both outputs of that channel low at E0. With D = `dead_cycles`, the newly active output rises at edge E0+D+1: the main output carries the reference and the complementary output carries its inverse.
- R3: Channel 4 has only a main output. It follows `ref_wave[3]` with the same dead-time timing as the other main outputs.
- R4: When edge E0 first samples `out_en` low, every output keeps its level through edge E0+D−1 and takes its idle level at edge E0+D. The idle bits are laid out as follows: `idle_rd[i]` for i = 0..3 is the idle level of main output i, and `idle_rd[4+j]` for j = 0..2 is the idle level of complementary output j.
- R5: While `out_en` has been high for the current and the previous edge, no channel has its main and complementary outputs high together.
- R6: At protection level 0, `idle_wr` loads `idle_wdata` into the idle bits. This includes a write in the same cycle as a lock write that raises the level.
- R7: At protection level 1, 2 or 3, idle writes are ignored, and `idle_rd` keeps showing the stored value.
- R8: A lock write raises `lock_level` to `lock_wdata` only when the new value is higher. Lower or equal values are ignored until reset.
- R9: When `out_en` returns high and the reference has not changed, both outputs of each pair are low from the first enabled edge F0 through F0+D−1, and the active levels appear at F0+D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| out_en | input | 1 | Master output enable |
| ref_wave | input | 4 | Reference waveforms, bit i for channel i+1 |
| dead_cycles | input | DT_W | Dead time in clock cycles |
| idle_wr | input | 1 | Idle-level write strobe |
| idle_wdata | input | 7 | Idle-level write data |
| idle_rd | output | 7 | Stored idle levels |
| lock_wr | input | 1 | Protection-level write strobe |
| lock_wdata | input | 2 | Requested protection level |
| lock_level | output | 2 | Current protection level |
| main_out | output | 4 | Main outputs, channels 1 to 4 |
| comp_out | output | 3 | Complementary outputs, channels 1 to 3 |

## Verification
The bench checks the exact edge on which the rising output of a pair appears, for a dead time of three cycles and for a dead time of zero. A design with an off-by-one counter would move that edge, and one that does not force both outputs low on a reference change would let the pair overlap. The bench also checks that the outputs hold for the dead time after the enable falls and then land on the correct idle bits. A swapped main and complementary idle bit, or an idle level applied at once, would show up as a wrong output vector. Finally, it writes idle bits in the same cycle that the lock rises, after the lock, and attempts to lower the lock, so a design that gates writes on the wrong cycle or lets the level fall is caught.

// File: rtl/cio_pkg.sv
// Shared definitions for the complementary output idle-state controller.
// Assumes a two-bit protection level and a four-way output drive selector.
package cio_pkg;
    localparam int LOCK_W = 2;

    // What an output register loads on the next edge.
    typedef enum logic [1:0] {
        DRV_LOW  = 2'd0,
        DRV_REF  = 2'd1,
        DRV_HOLD = 2'd2,
        DRV_IDLE = 2'd3
    } drv_e;
endpackage

// File: rtl/cio_idle_lock.sv
// Idle-level storage with a protection level that only reset can lower.
// Assumes that writes are single-cycle strobes. An idle write is judged
// against the level held before the current edge.
module cio_idle_lock #(
    parameter int N_IDLE = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      idle_wr,
    input  logic [N_IDLE-1:0]         idle_wdata,
    input  logic                      lock_wr,
    input  logic [cio_pkg::LOCK_W-1:0] lock_wdata,
    output logic [N_IDLE-1:0]         idle_q,
    output logic [cio_pkg::LOCK_W-1:0] lock_q
);
    // Protection level: only moves upward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else if (lock_wr && (lock_wdata > lock_q)) begin
            lock_q <= lock_wdata;
        end
    end

    // Idle levels: writable only while unprotected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (idle_wr && (lock_q == '0)) begin
            idle_q <= idle_wdata;
        end
    end
endmodule

// File: rtl/cio_dead_timer.sv
// Per-channel dead-time sequencer. It decides what the channel's output
// registers load on the next edge: low, the reference level, a hold or the
// idle level. Assumes that dead_cycles is stable while a count is running.
module cio_dead_timer #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            out_en,
    input  logic            ref_in,
    input  logic [DT_W-1:0] dead_cycles,
    output cio_pkg::drv_e   drv,
    output logic            ref_lvl
);
    import cio_pkg::*;

    logic            ref_q;
    logic [DT_W-1:0] gap_cnt;
    logic [DT_W-1:0] idle_cnt;

    // Reference tracking and both dead-time counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q    <= 1'b0;
            gap_cnt  <= '0;
            idle_cnt <= '0;
        end else if (out_en) begin
            idle_cnt <= dead_cycles;
            if (ref_in != ref_q) begin
                ref_q   <= ref_in;
                gap_cnt <= dead_cycles;
            end else if (gap_cnt != '0) begin
                gap_cnt <= gap_cnt - 1'b1;
            end
        end else begin
            ref_q   <= ref_in;
            gap_cnt <= dead_cycles;
            if (idle_cnt != '0) begin
                idle_cnt <= idle_cnt - 1'b1;
            end
        end
    end

    // Drive selection for the next edge.
    always_comb begin
        if (out_en) begin
            if ((ref_in != ref_q) || (gap_cnt != '0)) drv = DRV_LOW;
            else                                     drv = DRV_REF;
        end else begin
            if (idle_cnt != '0) drv = DRV_HOLD;
            else                drv = DRV_IDLE;
        end
    end

    assign ref_lvl = ref_q;
endmodule

// File: rtl/compl_idle_out.sv
// Complementary output stage: N_PAIR channels with main and complementary
// outputs plus one main-only channel, with dead time and idle levels.
// Assumes that the reference waveforms are synchronous to clk.
module compl_idle_out #(
    parameter int DT_W   = 8,
    parameter int N_PAIR = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       out_en,
    input  logic [N_PAIR:0]            ref_wave,
    input  logic [DT_W-1:0]            dead_cycles,
    input  logic                       idle_wr,
    input  logic [2*N_PAIR:0]          idle_wdata,
    output logic [2*N_PAIR:0]          idle_rd,
    input  logic                       lock_wr,
    input  logic [cio_pkg::LOCK_W-1:0] lock_wdata,
    output logic [cio_pkg::LOCK_W-1:0] lock_level,
    output logic [N_PAIR:0]            main_out,
    output logic [N_PAIR-1:0]          comp_out
);
    import cio_pkg::*;

    localparam int N_MAIN = N_PAIR + 1;
    localparam int N_IDLE = N_MAIN + N_PAIR;

    logic [N_IDLE-1:0] idle_q;
    drv_e              drv     [N_MAIN];
    logic [N_MAIN-1:0] ref_lvl;
    logic [N_MAIN-1:0] main_q;
    logic [N_PAIR-1:0] comp_q;

    cio_idle_lock #(.N_IDLE(N_IDLE)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_wr    (idle_wr),
        .idle_wdata (idle_wdata),
        .lock_wr    (lock_wr),
        .lock_wdata (lock_wdata),
        .idle_q     (idle_q),
        .lock_q     (lock_level)
    );

    for (genvar g = 0; g < N_MAIN; g++) begin : g_main
        cio_dead_timer #(.DT_W(DT_W)) u_dt (
            .clk         (clk),
            .rst_n       (rst_n),
            .out_en      (out_en),
            .ref_in      (ref_wave[g]),
            .dead_cycles (dead_cycles),
            .drv         (drv[g]),
            .ref_lvl     (ref_lvl[g])
        );

        // Main output register for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                main_q[g] <= 1'b0;
            end else begin
                case (drv[g])
                    DRV_LOW:  main_q[g] <= 1'b0;
                    DRV_REF:  main_q[g] <= ref_lvl[g];
                    DRV_HOLD: main_q[g] <= main_q[g];
                    DRV_IDLE: main_q[g] <= idle_q[g];
                    default:  main_q[g] <= 1'b0;
                endcase
            end
        end
    end

    for (genvar g = 0; g < N_PAIR; g++) begin : g_comp
        // Complementary output register for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                comp_q[g] <= 1'b0;
            end else begin
                case (drv[g])
                    DRV_LOW:  comp_q[g] <= 1'b0;
                    DRV_REF:  comp_q[g] <= ~ref_lvl[g];
                    DRV_HOLD: comp_q[g] <= comp_q[g];
                    DRV_IDLE: comp_q[g] <= idle_q[N_MAIN+g];
                    default:  comp_q[g] <= 1'b0;
                endcase
            end
        end
    end

    assign idle_rd  = idle_q;
    assign main_out = main_q;
    assign comp_out = comp_q;
endmodule

// File: rtl/compl_idle_out_chk.sv
// Property checker for compl_idle_out, attached by bind below.
// Assumes that reset is asserted from time zero.
module compl_idle_out_chk #(
    parameter int DT_W   = 8,
    parameter int N_PAIR = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       out_en,
    input logic [DT_W-1:0]            dead_cycles,
    input logic [2*N_PAIR:0]          idle_rd,
    input logic [cio_pkg::LOCK_W-1:0] lock_level,
    input logic [N_PAIR:0]            main_out,
    input logic [N_PAIR-1:0]          comp_out
);
    localparam int N_MAIN = N_PAIR + 1;

    for (genvar g = 0; g < N_PAIR; g++) begin : g_pair
        assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_en && $past(out_en)) |-> !(main_out[g] && comp_out[g]));

        assert_rise_after_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (out_en && $past(out_en) && $rose(main_out[g])) |-> !$past(comp_out[g]));
    end

    assert_lock_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_level >= $past(lock_level));

    assert_idle_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_level != '0) |=> $stable(idle_rd));

    assert_idle_apply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && $past(out_en) && ($past(dead_cycles) == '0)) |=>
        ((main_out == $past(idle_rd[N_MAIN-1:0])) &&
         (comp_out == $past(idle_rd[2*N_PAIR:N_MAIN]))));
endmodule

bind compl_idle_out compl_idle_out_chk #(.DT_W(DT_W), .N_PAIR(N_PAIR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_en      (out_en),
    .dead_cycles (dead_cycles),
    .idle_rd     (idle_rd),
    .lock_level  (lock_level),
    .main_out    (main_out),
    .comp_out    (comp_out)
);

// File: tb/test_compl_idle_out.sv
`timescale 1ns/1ps
module test_compl_idle_out;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       out_en = 1'b0;
    logic [3:0] ref_wave = '0;
    logic [7:0] dead_cycles = '0;
    logic       idle_wr = 1'b0;
    logic [6:0] idle_wdata = '0;
    logic [6:0] idle_rd;
    logic       lock_wr = 1'b0;
    logic [1:0] lock_wdata = '0;
    logic [1:0] lock_level;
    logic [3:0] main_out;
    logic [2:0] comp_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    compl_idle_out i_compl_idle_out (
        .clk(clk), .rst_n(rst_n), .out_en(out_en), .ref_wave(ref_wave),
        .dead_cycles(dead_cycles), .idle_wr(idle_wr), .idle_wdata(idle_wdata),
        .idle_rd(idle_rd), .lock_wr(lock_wr), .lock_wdata(lock_wdata),
        .lock_level(lock_level), .main_out(main_out), .comp_out(comp_out)
    );

    // Row: lock_wdata[19:18] lock_wr[17] idle_wdata[16:10] idle_wr[9]
    //      expected lock[8:7] expected idle[6:0]
    localparam logic [19:0] CFG_VEC [0:7] = '{
        {2'd0, 1'b0, 7'h55, 1'b1, 2'd0, 7'h55},
        {2'd0, 1'b0, 7'h2A, 1'b1, 2'd0, 7'h2A},
        {2'd1, 1'b1, 7'h11, 1'b1, 2'd1, 7'h11},
        {2'd0, 1'b0, 7'h7F, 1'b1, 2'd1, 7'h11},
        {2'd0, 1'b1, 7'h00, 1'b0, 2'd1, 7'h11},
        {2'd3, 1'b1, 7'h00, 1'b0, 2'd3, 7'h11},
        {2'd2, 1'b1, 7'h00, 1'b0, 2'd3, 7'h11},
        {2'd0, 1'b0, 7'h00, 1'b1, 2'd3, 7'h11}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check_out(input string req, input logic [3:0] m, input logic [2:0] c);
        check(req, {1'b0, main_out, comp_out}, {1'b0, m, c});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        edges(2);
        rst_n = 1'b1;
        check("R1", {1'b0, idle_rd}, 8'h00);
        check("R1", {6'd0, lock_level}, 8'h00);
        check_out("R1", 4'b0000, 3'b000);

        // Configuration and protection vectors (R6, R7, R8)
        for (int r = 0; r < 8; r++) begin
            lock_wdata = CFG_VEC[r][19:18];
            lock_wr    = CFG_VEC[r][17];
            idle_wdata = CFG_VEC[r][16:10];
            idle_wr    = CFG_VEC[r][9];
            edges(1);
            lock_wr = 1'b0;
            idle_wr = 1'b0;
            check(r < 3 ? "R6 idle write" : "R7 idle frozen", {1'b0, idle_rd}, {1'b0, CFG_VEC[r][6:0]});
            check("R8 lock level", {6'd0, lock_level}, {6'd0, CFG_VEC[r][8:7]});
        end

        // Reset clears protection and idle bits (R1)
        rst_n = 1'b0;
        edges(2);
        rst_n = 1'b1;
        check("R1 after lock", {6'd0, lock_level}, 8'h00);
        check("R1 after lock", {1'b0, idle_rd}, 8'h00);

        // Idle levels: mains 0110, comps 101
        idle_wdata = 7'b101_0110;
        idle_wr = 1'b1;
        edges(1);
        idle_wr = 1'b0;
        check("R6", {1'b0, idle_rd}, 8'h56);

        // Active path with D=3 (R2, R3, R5)
        out_en = 1'b1;
        dead_cycles = 8'd3;
        ref_wave = 4'b0000;
        edges(3);
        check_out("R2 steady low ref", 4'b0000, 3'b111);
        ref_wave = 4'b0001;
        edges(1);
        check_out("R2 both low at change", 4'b0000, 3'b110);
        edges(3);
        check_out("R2 dead time holding", 4'b0000, 3'b110);
        edges(1);
        check_out("R2 main rises at D+1", 4'b0001, 3'b110);
        check("R5", {5'd0, main_out[2:0] & comp_out}, 8'h00);
        ref_wave = 4'b1001;
        edges(4);
        check_out("R3 ch4 before D+1", 4'b0001, 3'b110);
        edges(1);
        check_out("R3 ch4 rises at D+1", 4'b1001, 3'b110);
        ref_wave = 4'b1000;
        edges(1);
        check_out("R2 main falls at once", 4'b1000, 3'b110);
        edges(4);
        check_out("R2 comp rises at D+1", 4'b1000, 3'b111);
        check("R5", {5'd0, main_out[2:0] & comp_out}, 8'h00);

        // Zero dead time (R2)
        dead_cycles = 8'd0;
        ref_wave = 4'b1001;
        edges(1);
        check_out("R2 D=0 gap", 4'b1000, 3'b110);
        edges(1);
        check_out("R2 D=0 active", 4'b1001, 3'b110);

        // Enable falls with D=2 (R4)
        dead_cycles = 8'd2;
        edges(1);
        out_en = 1'b0;
        edges(1);
        check_out("R4 hold first", 4'b1001, 3'b110);
        edges(1);
        check_out("R4 hold last", 4'b1001, 3'b110);
        edges(1);
        check_out("R4 idle levels", 4'b0110, 3'b101);

        // Re-enable with D=2 (R9)
        out_en = 1'b1;
        edges(1);
        check_out("R9 low at F0", 4'b0000, 3'b000);
        edges(1);
        check_out("R9 low at F1", 4'b0000, 3'b000);
        edges(1);
        check_out("R9 active at F2", 4'b1001, 3'b110);

        // Enable falls with D=0 (R4)
        dead_cycles = 8'd0;
        edges(1);
        out_en = 1'b0;
        edges(1);
        check_out("R4 D=0 idle at once", 4'b0110, 3'b101);

        finish_run();
    end
endmodule